// File: doc/BRIEF.md
# DRAM Bank with SRAM Row Cache

This block models one DRAM bank whose sensed row is copied into an 8 kbit SRAM row buffer, together with the command sequencer that drives it. A host request carries a row, a column, a write flag and write data under a valid/ready handshake. When the requested row is already held in the buffer, the column is decoded against the buffer alone and the storage array is not touched. When it is not, the sequencer activates the row, waits a configurable row-to-column delay, copies the whole row into the buffer and then serves the column from the buffer.

In the default row-cache mode the array is precharged in the cycle right after the copy, so the bank is never left open. A later miss therefore goes straight to activate. A mode input selects a conventional open-page reference instead. In that mode the page stays open after activation, and a miss to an open bank must first precharge and sit out a close penalty before the new activate. This lets a bench compare the latency of the two policies through the hit, miss and busy-cycle counters.

Writes go to both the buffer and the array. The row select of the array is split into two independent half-row lines. An activate raises both lines. A write raises only the half that holds the column.

Top module: `rowcache_bank`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0, all three counters are 0, and the first request is a miss whatever row was cached before the reset.
- R2: A read whose row matches the valid cached row raises rsp_valid for one cycle, exactly 1 clock edge after the accepting edge, with the cached word on rsp_data, and issues no cmd_act.
- R3: In row-cache mode a miss issues exactly one cmd_act, visible for the cycle after the accepting edge with hemi_sel equal to 2'b11, and completes TRCD+2 edges after the accepting edge (the read response or req_ready returning high).
- R4: In row-cache mode every miss issues exactly one cmd_pre, visible TRCD+1 edges after the accepting edge (the cycle after the copy), and cmd_pre is only issued to an open bank.
- R5: In row-cache mode consecutive misses to different rows each take TRCD+2 edges, with no close-page penalty, and an activate is never issued to an open bank.
- R6: In open-page mode (open_page_mode = 1) a miss to an open bank issues cmd_pre in the first cycle after the accepting edge and completes TCLOSE+TRCD+2 edges after it. A miss to a closed bank issues no cmd_pre and completes in TRCD+2 edges.
- R7: A write updates both the row buffer and the array, so a read of that word after its row has been replaced, or after a reset, returns the written value. A write produces no response, and its completion time follows R2 and R3.
- R8: During a write, hemi_sel is one-hot and selects the half that holds the column: 2'b01 when the column MSB is 0, 2'b10 when it is 1.
- R9: hit_count and miss_count each rise by one for every accepted hit or miss. stall_count counts every cycle in which the sequencer is not idle.
- R10: req_ready is high only while the sequencer is idle, and rsp_valid never stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| open_page_mode | input | 1 | 1 selects the open-page reference policy; change only while idle |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_row | input | ROW_W | Row address |
| req_col | input | COL_W | Column address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle read response strobe |
| rsp_data | output | DATA_W | Read data |
| cmd_act | output | 1 | Activate issued to the array |
| cmd_pre | output | 1 | Precharge-all issued to the array |
| hemi_sel | output | 2 | Half-row select lines (bit 0 lower half, bit 1 upper half) |
| hit_count | output | CNT_W | Requests that hit the cached row |
| miss_count | output | CNT_W | Requests that missed |
| stall_count | output | CNT_W | Cycles the sequencer was busy |

## Verification
On every cycle the assertions check the array-side command protocol: an activate only to a closed bank with both half lines raised, a precharge only to an open bank, a write with exactly the half line of its column, buffer reads only under a valid tag, a single-cycle response strobe, and the hit/miss counters stepping once per accepted request. Only the bench scenarios show latency per path, the exact cycle of the precharge, and data surviving replacement and reset through the write-through path. They also show the close penalty that the open-page mode adds over the row-cache mode for the same miss pattern.

// File: rtl/rcb_pkg.sv
package rcb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLOSE,
        ST_ACT,
        ST_COPY,
        ST_RD,
        ST_WR
    } state_e;

    localparam int HALVES = 2;

endpackage

// File: rtl/rcb_array.sv
module rcb_array #(
    parameter int ROW_W  = 2,
    parameter int COL_W  = 9,
    parameter int DATA_W = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        act_i,
    input  logic                        pre_i,
    input  logic [1:0]                  hemi_i,
    input  logic [ROW_W-1:0]            row_i,
    input  logic                        wr_i,
    input  logic [COL_W-1:0]            col_i,
    input  logic [DATA_W-1:0]           wdata_i,
    output logic [(1<<COL_W)*DATA_W-1:0] sense_o
);
    localparam int ROWS = 1 << ROW_W;
    localparam int COLS = 1 << COL_W;
    localparam int HALF = COLS / rcb_pkg::HALVES;

    logic [DATA_W-1:0]           cells_q [ROWS][COLS];
    logic [COLS*DATA_W-1:0]      sense_q;
    logic                        open_q;

    // write-through port: only the selected half-row line lets data in
    always_ff @(posedge clk) begin
        if (wr_i && hemi_i[col_i[COL_W-1]]) begin
            cells_q[row_i][col_i] <= wdata_i;
        end
    end

    // sense latch, one half per select line
    for (genvar h = 0; h < rcb_pkg::HALVES; h++) begin : g_half
        always_ff @(posedge clk) begin
            if (act_i && hemi_i[h]) begin
                for (int c = 0; c < HALF; c++) begin
                    sense_q[(h*HALF+c)*DATA_W +: DATA_W] <= cells_q[row_i][h*HALF+c];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            open_q <= 1'b0;
        end else if (act_i) begin
            open_q <= 1'b1;
        end else if (pre_i) begin
            open_q <= 1'b0;
        end
    end

    assign sense_o = sense_q;

    // R3
    act_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_i |-> (hemi_i == 2'b11));
    // R5
    act_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_i |-> !open_q);
    // R4
    pre_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pre_i |-> open_q);
    // R8
    wr_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |-> ($countones(hemi_i) == 1) && hemi_i[col_i[COL_W-1]]);

endmodule

// File: rtl/rcb_cache.sv
module rcb_cache #(
    parameter int ROW_W  = 2,
    parameter int COL_W  = 9,
    parameter int DATA_W = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        load_i,
    input  logic [1:0]                  hemi_i,
    input  logic [ROW_W-1:0]            row_i,
    input  logic [(1<<COL_W)*DATA_W-1:0] sense_i,
    input  logic                        wr_i,
    input  logic                        rd_i,
    input  logic [COL_W-1:0]            col_i,
    input  logic [DATA_W-1:0]           wdata_i,
    output logic                        tag_valid_o,
    output logic [ROW_W-1:0]            tag_row_o,
    output logic [DATA_W-1:0]           rdata_o
);
    localparam int COLS = 1 << COL_W;
    localparam int HALF = COLS / rcb_pkg::HALVES;

    logic [DATA_W-1:0] line_q [COLS];
    logic              valid_q;
    logic [ROW_W-1:0]  tag_q;
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (load_i) begin
            for (int c = 0; c < COLS; c++) begin
                if (hemi_i[c / HALF]) begin
                    line_q[c] <= sense_i[c*DATA_W +: DATA_W];
                end
            end
        end else if (wr_i) begin
            line_q[col_i] <= wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            tag_q   <= '0;
            rdata_q <= '0;
        end else begin
            if (load_i) begin
                valid_q <= 1'b1;
                tag_q   <= row_i;
            end
            if (rd_i) begin
                rdata_q <= line_q[col_i];
            end
        end
    end

    assign tag_valid_o = valid_q;
    assign tag_row_o   = tag_q;
    assign rdata_o     = rdata_q;

    // R2
    rd_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_i |-> valid_q);

endmodule

// File: rtl/rcb_ctrl.sv
module rcb_ctrl
    import rcb_pkg::*;
#(
    parameter int ROW_W  = 2,
    parameter int COL_W  = 9,
    parameter int DATA_W = 16,
    parameter int TRCD   = 3,
    parameter int TCLOSE = 2,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              open_mode_i,
    input  logic              req_valid_i,
    output logic              req_ready_o,
    input  logic              req_write_i,
    input  logic [ROW_W-1:0]  req_row_i,
    input  logic [COL_W-1:0]  req_col_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    input  logic              tag_valid_i,
    input  logic [ROW_W-1:0]  tag_row_i,
    output logic              cache_load_o,
    output logic              cache_rd_o,
    output logic              cache_wr_o,
    output logic              arr_act_o,
    output logic              arr_pre_o,
    output logic              arr_wr_o,
    output logic [1:0]        hemi_o,
    output logic [ROW_W-1:0]  row_o,
    output logic [COL_W-1:0]  col_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic              rsp_valid_o,
    output logic [CNT_W-1:0]  hits_o,
    output logic [CNT_W-1:0]  misses_o,
    output logic [CNT_W-1:0]  stalls_o
);
    localparam int TMAX = (TRCD > TCLOSE) ? TRCD : TCLOSE;
    localparam int TW   = $clog2(TMAX + 1);

    typedef struct packed {
        state_e            state;
        logic [TW-1:0]     cnt;
        logic              act;
        logic              pre;
        logic              rsp;
        logic              open;
        logic              wr;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic [DATA_W-1:0] wdata;
        logic [CNT_W-1:0]  hits;
        logic [CNT_W-1:0]  misses;
        logic [CNT_W-1:0]  stalls;
    } ctrl_t;

    ctrl_t d, q;
    logic  hit;
    logic [CNT_W-1:0] served;

    assign hit = tag_valid_i && (tag_row_i == req_row_i);

    always_comb begin
        d     = q;
        d.act = 1'b0;
        d.pre = 1'b0;
        d.rsp = 1'b0;
        if (q.act) d.open = 1'b1;
        if (q.pre) d.open = 1'b0;
        if (q.state != ST_IDLE) d.stalls = q.stalls + 1'b1;
        unique case (q.state)
            ST_IDLE: begin
                if (req_valid_i) begin
                    d.row   = req_row_i;
                    d.col   = req_col_i;
                    d.wr    = req_write_i;
                    d.wdata = req_wdata_i;
                    if (hit) begin
                        d.hits  = q.hits + 1'b1;
                        d.state = req_write_i ? ST_WR : ST_RD;
                    end else begin
                        d.misses = q.misses + 1'b1;
                        if (open_mode_i && q.open) begin
                            d.state = ST_CLOSE;
                            d.cnt   = TW'(TCLOSE - 1);
                            d.pre   = 1'b1;
                        end else begin
                            d.state = ST_ACT;
                            d.cnt   = TW'(TRCD - 1);
                            d.act   = 1'b1;
                        end
                    end
                end
            end
            ST_CLOSE: begin
                if (q.cnt == '0) begin
                    d.state = ST_ACT;
                    d.cnt   = TW'(TRCD - 1);
                    d.act   = 1'b1;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_ACT: begin
                if (q.cnt == '0) d.state = ST_COPY;
                else             d.cnt   = q.cnt - 1'b1;
            end
            ST_COPY: begin
                d.state = q.wr ? ST_WR : ST_RD;
                d.pre   = !open_mode_i;
            end
            ST_RD: begin
                d.rsp   = 1'b1;
                d.state = ST_IDLE;
            end
            ST_WR: begin
                d.state = ST_IDLE;
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        hemi_o = 2'b00;
        if (q.act || q.state == ST_COPY) hemi_o = 2'b11;
        else if (q.state == ST_WR)       hemi_o = q.col[COL_W-1] ? 2'b10 : 2'b01;
    end

    assign req_ready_o  = (q.state == ST_IDLE);
    assign cache_load_o = (q.state == ST_COPY);
    assign cache_rd_o   = (q.state == ST_RD);
    assign cache_wr_o   = (q.state == ST_WR);
    assign arr_wr_o     = (q.state == ST_WR);
    assign arr_act_o    = q.act;
    assign arr_pre_o    = q.pre;
    assign row_o        = q.row;
    assign col_o        = q.col;
    assign wdata_o      = q.wdata;
    assign rsp_valid_o  = q.rsp;
    assign hits_o       = q.hits;
    assign misses_o     = q.misses;
    assign stalls_o     = q.stalls;
    assign served       = q.hits + q.misses;

    // R10
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |=> !rsp_valid_o);
    // R9
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_ready_o) |=> (served == $past(served) + 1'b1));

endmodule

// File: rtl/rowcache_bank.sv
module rowcache_bank #(
    parameter int ROW_W  = 2,
    parameter int COL_W  = 9,
    parameter int DATA_W = 16,
    parameter int TRCD   = 3,
    parameter int TCLOSE = 2,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              open_page_mode,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              cmd_act,
    output logic              cmd_pre,
    output logic [1:0]        hemi_sel,
    output logic [CNT_W-1:0]  hit_count,
    output logic [CNT_W-1:0]  miss_count,
    output logic [CNT_W-1:0]  stall_count
);
    localparam int ROW_BITS = (1 << COL_W) * DATA_W;

    logic                tag_valid;
    logic [ROW_W-1:0]    tag_row;
    logic                cache_load, cache_rd, cache_wr, arr_wr;
    logic [ROW_W-1:0]    op_row;
    logic [COL_W-1:0]    op_col;
    logic [DATA_W-1:0]   op_wdata;
    logic [ROW_BITS-1:0] sense;

    rcb_ctrl #(
        .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
        .TRCD(TRCD), .TCLOSE(TCLOSE), .CNT_W(CNT_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .open_mode_i  (open_page_mode),
        .req_valid_i  (req_valid),
        .req_ready_o  (req_ready),
        .req_write_i  (req_write),
        .req_row_i    (req_row),
        .req_col_i    (req_col),
        .req_wdata_i  (req_wdata),
        .tag_valid_i  (tag_valid),
        .tag_row_i    (tag_row),
        .cache_load_o (cache_load),
        .cache_rd_o   (cache_rd),
        .cache_wr_o   (cache_wr),
        .arr_act_o    (cmd_act),
        .arr_pre_o    (cmd_pre),
        .arr_wr_o     (arr_wr),
        .hemi_o       (hemi_sel),
        .row_o        (op_row),
        .col_o        (op_col),
        .wdata_o      (op_wdata),
        .rsp_valid_o  (rsp_valid),
        .hits_o       (hit_count),
        .misses_o     (miss_count),
        .stalls_o     (stall_count)
    );

    rcb_array #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .act_i   (cmd_act),
        .pre_i   (cmd_pre),
        .hemi_i  (hemi_sel),
        .row_i   (op_row),
        .wr_i    (arr_wr),
        .col_i   (op_col),
        .wdata_i (op_wdata),
        .sense_o (sense)
    );

    rcb_cache #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_cache (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (cache_load),
        .hemi_i      (hemi_sel),
        .row_i       (op_row),
        .sense_i     (sense),
        .wr_i        (cache_wr),
        .rd_i        (cache_rd),
        .col_i       (op_col),
        .wdata_i     (op_wdata),
        .tag_valid_o (tag_valid),
        .tag_row_o   (tag_row),
        .rdata_o     (rsp_data)
    );

endmodule

// File: tb/rowcache_bank_test.sv
`timescale 1ns/1ps
module rowcache_bank_test;
    localparam int ROW_W  = 2;
    localparam int COL_W  = 9;
    localparam int DATA_W = 16;
    localparam int TRCD   = 3;
    localparam int TCLOSE = 2;
    localparam int CNT_W  = 32;
    localparam int MISS_LAT  = TRCD + 2;
    localparam int CLOSE_LAT = TCLOSE + TRCD + 2;
    localparam int NVEC = 11;

    typedef struct packed {
        logic              wr;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic [DATA_W-1:0] data;
        logic [3:0]        lat;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        {1'b1, 2'd1, 9'd5,   16'hA1A1, 4'd5},
        {1'b0, 2'd1, 9'd5,   16'hA1A1, 4'd1},
        {1'b1, 2'd1, 9'd300, 16'hB2B2, 4'd1},
        {1'b0, 2'd1, 9'd300, 16'hB2B2, 4'd1},
        {1'b1, 2'd2, 9'd5,   16'hC3C3, 4'd5},
        {1'b0, 2'd2, 9'd5,   16'hC3C3, 4'd1},
        {1'b0, 2'd1, 9'd5,   16'hA1A1, 4'd5},
        {1'b0, 2'd1, 9'd300, 16'hB2B2, 4'd1},
        {1'b1, 2'd3, 9'd511, 16'hD4D4, 4'd5},
        {1'b0, 2'd3, 9'd511, 16'hD4D4, 4'd1},
        {1'b0, 2'd2, 9'd5,   16'hC3C3, 4'd5}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              open_page_mode = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_write = 1'b0;
    logic [ROW_W-1:0]  req_row = '0;
    logic [COL_W-1:0]  req_col = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              rsp_valid;
    logic [DATA_W-1:0] rsp_data;
    logic              cmd_act, cmd_pre;
    logic [1:0]        hemi_sel;
    logic [CNT_W-1:0]  hit_count, miss_count, stall_count;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int got_lat, act_n, pre_n, pre_at;
    logic [DATA_W-1:0] got_data;
    logic [1:0]        wr_hemi;
    bit                act_hemi_bad;

    always #2 clk = ~clk;

    rowcache_bank #(
        .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
        .TRCD(TRCD), .TCLOSE(TCLOSE), .CNT_W(CNT_W)
    ) uut (
        .clk(clk), .rst_n(rst_n), .open_page_mode(open_page_mode),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_row(req_row), .req_col(req_col), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .cmd_act(cmd_act), .cmd_pre(cmd_pre), .hemi_sel(hemi_sel),
        .hit_count(hit_count), .miss_count(miss_count), .stall_count(stall_count)
    );

    task automatic check_eq(input string what, input longint got, input longint exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", what, got, exp);
        end
    endtask

    task automatic do_reset(input logic mode);
        @(negedge clk);
        rst_n = 1'b0;
        req_valid = 1'b0;
        open_page_mode = mode;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // issue one request; returns at the negedge where it is complete
    task automatic do_req(input logic wr, input logic [ROW_W-1:0] row,
                          input logic [COL_W-1:0] col, input logic [DATA_W-1:0] data);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_row   = row;
        req_col   = col;
        req_wdata = data;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        got_lat = 0; act_n = 0; pre_n = 0; pre_at = -1;
        wr_hemi = 2'b00; act_hemi_bad = 1'b0; got_data = '0;
        while (got_lat < 60) begin
            if (cmd_act) begin
                act_n++;
                if (hemi_sel != 2'b11) act_hemi_bad = 1'b1;
            end
            if (cmd_pre) begin
                pre_n++;
                pre_at = got_lat;
            end
            if (!cmd_act && hemi_sel != 2'b00 && hemi_sel != 2'b11) wr_hemi = hemi_sel;
            if (!wr && rsp_valid) begin
                got_data = rsp_data;
                break;
            end
            if (wr && req_ready) break;
            got_lat++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int exp_hits, exp_miss, exp_stall;
        do_reset(1'b0);

        // R1 reset state
        check_eq("R1 req_ready after reset", req_ready, 1);
        check_eq("R1 rsp_valid after reset", rsp_valid, 0);
        check_eq("R1 hit_count after reset", hit_count, 0);
        check_eq("R1 miss_count after reset", miss_count, 0);
        check_eq("R1 stall_count after reset", stall_count, 0);

        // table walk in row-cache mode
        exp_hits = 0; exp_miss = 0; exp_stall = 0;
        for (int i = 0; i < NVEC; i++) begin
            vec_t v;
            bit   miss;
            v = VECS[i];
            miss = (v.lat != 4'd1);
            do_req(v.wr, v.row, v.col, v.data);
            check_eq($sformatf("R2/R3/R5 latency vec %0d", i), got_lat, v.lat);
            check_eq($sformatf("R3 activate count vec %0d", i), act_n, miss ? 1 : 0);
            check_eq($sformatf("R3 activate half lines vec %0d", i), act_hemi_bad, 0);
            check_eq($sformatf("R4 precharge count vec %0d", i), pre_n, miss ? 1 : 0);
            if (miss) check_eq($sformatf("R4 precharge cycle vec %0d", i), pre_at, TRCD + 1);
            if (v.wr) check_eq($sformatf("R8 write half line vec %0d", i), wr_hemi,
                               v.col[COL_W-1] ? 2'b10 : 2'b01);
            else      check_eq($sformatf("R2/R7 read data vec %0d", i), got_data, v.data);
            if (miss) exp_miss++; else exp_hits++;
            exp_stall += v.lat;
        end
        check_eq("R9 hit_count", hit_count, exp_hits);
        check_eq("R9 miss_count", miss_count, exp_miss);
        check_eq("R9 stall_count", stall_count, exp_stall);

        // R10 single-cycle response, ready while idle
        do_req(1'b0, 2'd2, 9'd5, '0);
        check_eq("R10 ready with response", req_ready, 1);
        @(negedge clk);
        check_eq("R10 response drops", rsp_valid, 0);

        // open-page reference mode
        do_reset(1'b1);
        do_req(1'b1, 2'd1, 9'd7, 16'hE5E5);
        check_eq("R6 miss to closed bank latency", got_lat, MISS_LAT);
        check_eq("R6 miss to closed bank no precharge", pre_n, 0);
        do_req(1'b0, 2'd1, 9'd7, '0);
        check_eq("R2 open-page hit latency", got_lat, 1);
        check_eq("R2 open-page hit data", got_data, 16'hE5E5);
        do_req(1'b0, 2'd2, 9'd5, '0);
        check_eq("R6 miss to open bank latency", got_lat, CLOSE_LAT);
        check_eq("R6 close precharge count", pre_n, 1);
        check_eq("R6 close precharge cycle", pre_at, 0);
        check_eq("R6 activate after close", act_n, 1);
        check_eq("R7 data after open-page miss", got_data, 16'hC3C3);
        check_eq("R9 open-page stall_count", stall_count, MISS_LAT + 1 + CLOSE_LAT);

        // R1 first request after reset is a miss even for the last cached row
        do_reset(1'b0);
        do_req(1'b0, 2'd2, 9'd5, '0);
        check_eq("R1 first request latency", got_lat, MISS_LAT);
        check_eq("R1 first request counted miss", miss_count, 1);
        check_eq("R1 first request data", got_data, 16'hC3C3);
        do_req(1'b0, 2'd1, 9'd7, '0);
        check_eq("R7 write from open-page run survives", got_data, 16'hE5E5);
        check_eq("R5 back-to-back miss latency", got_lat, MISS_LAT);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule